// File: doc/BRIEF.md
# Online Signed-Digit Maximum/Minimum Selector

This block picks the larger of two numbers that arrive one digit per clock, most significant digit first, in radix-2 signed-digit form. Each digit is -1, 0 or +1, so one value can have many encodings. A one-bit mode selects the smaller operand instead. The block is the global reduction stage of a neighbourhood max or min filter. A wider window is handled by chaining several copies.

The selector does not wait for the whole word. It keeps a five-state record of the prefix difference X−Y: at or below −2, −1, 0, +1, at or above +2. From this state and the current digit pair it emits one result digit per cycle, and the result digits always spell the exact extremum. Min is built from max by negating both inputs and the result, where negating a digit swaps its two bits. Each digit reaches the output three cycles after it enters. Words follow each other with no gap, and a start strobe marks the first digit of each word.

Top module: `sdmm_maxmin`

## Requirements
- R1: A digit is two bits {pos, neg} with value pos−neg: 2'b10 is +1, 2'b01 is −1, 2'b00 and 2'b11 are 0. The output never carries 2'b11.
- R2: A digit applied in clock cycle k appears on the output in cycle k+3.
- R3: With max mode in force, the output word has the value max(X, Y).
- R4: With min mode in force, the output word has the value min(X, Y).
- R5: When X and Y have equal value, even with different digit encodings, the output word has that value.
- R6: The mode input is sampled only in the cycle that carries the start strobe and holds for the whole word. Changes on other cycles have no effect.
- R7: The start strobe returns the prefix difference to zero, so back-to-back words are resolved independently of earlier words.
- R8: While reset is high, the output digit is 2'b00 on the following cycle.
- R9: Once the prefix difference reaches ±2, every later output digit of that word has the value of the winning operand's digit. In min mode the winner is the smaller operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_dig_i | input | 2 | Digit of operand X, {pos, neg} |
| y_dig_i | input | 2 | Digit of operand Y, {pos, neg} |
| word_start_i | input | 1 | High on the most significant digit of each word |
| min_mode_i | input | 1 | 1 selects minimum, 0 selects maximum; read with the start strobe |
| z_dig_o | output | 2 | Result digit, {pos, neg}, three cycles behind the inputs |

## Verification
The hardest cases are words whose leader is known only at the last digit, and pairs that tie in value while differing digit by digit. In both, the selector sits in the ±1 or 0 state for the whole word and its correction terms decide the result. The stimulus builds tied pairs by splitting an odd value two ways: once with a trailing +1 digit and once with a trailing −1 digit. Near-tie rows such as 128 against 127 hold the prefix difference at +1 until the end. The mode input is toggled on every non-start cycle, so a selector that reads the mode mid-word gives a wrong value.

// File: rtl/sdmm_pkg.sv
`timescale 1ns/1ps
package sdmm_pkg;

    localparam int DIGIT_W = 2;
    localparam int DIFF_W  = 4;

    typedef struct packed {
        logic pos;
        logic neg;
    } sd_digit_t;

    typedef logic signed [1:0]        dval_t;
    typedef logic signed [DIFF_W-1:0] dwide_t;

    // saturated prefix difference X - Y
    typedef enum logic [2:0] {
        DF_NEG_BIG,
        DF_NEG_ONE,
        DF_EVEN,
        DF_POS_ONE,
        DF_POS_BIG
    } diff_t;

    typedef struct packed {
        logic      first;
        logic      flip;
        sd_digit_t a;
        sd_digit_t b;
    } lane_t;

    typedef struct packed {
        logic      flip;
        sd_digit_t z;
    } pick_t;

    function automatic sd_digit_t sd_neg(sd_digit_t d);
        sd_digit_t r;
        r.pos = d.neg;
        r.neg = d.pos;
        return r;
    endfunction

    function automatic dval_t sd_val(sd_digit_t d);
        if (d.pos && !d.neg) return 2'sb01;
        if (d.neg && !d.pos) return 2'sb11;
        return 2'sb00;
    endfunction

    function automatic sd_digit_t sd_enc(dval_t v);
        sd_digit_t r;
        r.pos = (v == 2'sb01);
        r.neg = (v == 2'sb11);
        return r;
    endfunction

    function automatic dwide_t ext(dval_t v);
        return {{(DIFF_W-2){v[1]}}, v};
    endfunction

    function automatic dwide_t diff_num(diff_t s);
        case (s)
            DF_NEG_BIG: return -4'sd2;
            DF_NEG_ONE: return -4'sd1;
            DF_POS_ONE: return 4'sd1;
            DF_POS_BIG: return 4'sd2;
            default:    return 4'sd0;
        endcase
    endfunction

    function automatic diff_t diff_next(diff_t s, dval_t a, dval_t b);
        dwide_t t;
        t = (diff_num(s) <<< 1) + ext(a) - ext(b);
        if (t >= 4'sd2)  return DF_POS_BIG;
        if (t <= -4'sd2) return DF_NEG_BIG;
        if (t == 4'sd1)  return DF_POS_ONE;
        if (t == -4'sd1) return DF_NEG_ONE;
        return DF_EVEN;
    endfunction

    // increment of max prefix: always within -1..+1
    function automatic dval_t max_digit(diff_t s, dval_t a, dval_t b);
        dwide_t ea, eb;
        ea = ext(a);
        eb = ext(b);
        case (s)
            DF_POS_BIG: return a;
            DF_NEG_BIG: return b;
            DF_POS_ONE: eb = eb - 4'sd2;
            DF_NEG_ONE: ea = ea - 4'sd2;
            default:    ;
        endcase
        return (ea >= eb) ? dval_t'(ea) : dval_t'(eb);
    endfunction

endpackage

// File: rtl/sdmm_front.sv
`timescale 1ns/1ps
module sdmm_front
    import sdmm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sd_digit_t x_i,
    input  sd_digit_t y_i,
    input  logic      start_i,
    input  logic      min_i,
    output lane_t     lane_o
);

    logic min_hold_q;
    logic min_eff;

    assign min_eff = start_i ? min_i : min_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            min_hold_q <= 1'b0;
            lane_o     <= '0;
        end else begin
            min_hold_q   <= min_eff;
            lane_o.first <= start_i;
            lane_o.flip  <= min_eff;
            lane_o.a     <= min_eff ? sd_neg(x_i) : x_i;
            lane_o.b     <= min_eff ? sd_neg(y_i) : y_i;
        end
    end

    // R6: mode seen by the pipeline only changes on a start digit
    a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (lane_o.flip == $past(lane_o.flip)));

endmodule

// File: rtl/sdmm_select.sv
`timescale 1ns/1ps
module sdmm_select
    import sdmm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t lane_i,
    output pick_t pick_o
);

    diff_t st_q;
    diff_t st_base;
    diff_t st_d;
    dval_t va;
    dval_t vb;
    dval_t m;

    always_comb begin
        st_base = lane_i.first ? DF_EVEN : st_q;
        va      = sd_val(lane_i.a);
        vb      = sd_val(lane_i.b);
        m       = max_digit(st_base, va, vb);
        st_d    = diff_next(st_base, va, vb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= DF_EVEN;
            pick_o <= '0;
        end else begin
            st_q        <= st_d;
            pick_o.flip <= lane_i.flip;
            pick_o.z    <= sd_enc(m);
        end
    end

    // R9: a decided word stays decided
    a_r9_hi_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == DF_POS_BIG && !lane_i.first) |=> (st_q == DF_POS_BIG));

    a_r9_lo_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q == DF_NEG_BIG && !lane_i.first) |=> (st_q == DF_NEG_BIG));

    // R9: a decided word follows the leading operand
    a_r9_follow_a: assert property (@(posedge clk) disable iff (rst)
        (st_q == DF_POS_BIG && !lane_i.first)
        |=> (sd_val(pick_o.z) == $past(sd_val(lane_i.a))));

    // R7: a start digit with equal digits leaves the difference at zero
    a_r7_fresh_word: assert property (@(posedge clk) disable iff (rst)
        (lane_i.first && sd_val(lane_i.a) == sd_val(lane_i.b))
        |=> (st_q == DF_EVEN));

endmodule

// File: rtl/sdmm_back.sv
`timescale 1ns/1ps
module sdmm_back
    import sdmm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pick_t     pick_i,
    output sd_digit_t z_o
);

    always_ff @(posedge clk) begin
        if (rst) z_o <= '0;
        else     z_o <= pick_i.flip ? sd_neg(pick_i.z) : pick_i.z;
    end

    // R1: output digits never use the redundant zero code
    a_r1_canonical: assert property (@(posedge clk) disable iff (rst)
        !(z_o.pos && z_o.neg));

endmodule

// File: rtl/sdmm_maxmin.sv
`timescale 1ns/1ps
module sdmm_maxmin
    import sdmm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] x_dig_i,
    input  logic [DIGIT_W-1:0] y_dig_i,
    input  logic               word_start_i,
    input  logic               min_mode_i,
    output logic [DIGIT_W-1:0] z_dig_o
);

    lane_t     lane;
    pick_t     pick;
    sd_digit_t z_s;

    sdmm_front u_front (
        .clk     (clk),
        .rst     (rst),
        .x_i     (sd_digit_t'(x_dig_i)),
        .y_i     (sd_digit_t'(y_dig_i)),
        .start_i (word_start_i),
        .min_i   (min_mode_i),
        .lane_o  (lane)
    );

    sdmm_select u_select (
        .clk    (clk),
        .rst    (rst),
        .lane_i (lane),
        .pick_o (pick)
    );

    sdmm_back u_back (
        .clk    (clk),
        .rst    (rst),
        .pick_i (pick),
        .z_o    (z_s)
    );

    assign z_dig_o = z_s;

    // R8: reset clears the output digit
    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (z_dig_o == '0));

endmodule

// File: tb/sdmm_maxmin_bench.sv
`timescale 1ns/1ps
module sdmm_maxmin_bench;

    localparam int N    = 8;
    localparam int MAXW = 64;
    localparam int NTAB = 10;

    // {min_mode, X digits, Y digits}, two bits per digit, MSB first
    localparam logic [32:0] TAB [NTAB] = '{
        {1'b0, 16'h8000, 16'h2AAA},
        {1'b0, 16'h9000, 16'h2000},
        {1'b1, 16'h8000, 16'h2AAA},
        {1'b0, 16'h4000, 16'h1555},
        {1'b1, 16'h4000, 16'h1555},
        {1'b0, 16'hFFFF, 16'h0044},
        {1'b1, 16'hFFFF, 16'h0088},
        {1'b1, 16'h9000, 16'h2000},
        {1'b0, 16'h0001, 16'h0002},
        {1'b1, 16'h5555, 16'hAAAA}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] xd, yd;
    logic       st, mm;
    logic [1:0] zd;

    logic [15:0] wx [MAXW];
    logic [15:0] wy [MAXW];
    logic        wm [MAXW];
    logic [1:0]  got_dig [MAXW][N];
    logic [1:0]  pre_dig [3];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sdmm_maxmin u_sdmm_maxmin (
        .clk          (clk),
        .rst          (rst),
        .x_dig_i      (xd),
        .y_dig_i      (yd),
        .word_start_i (st),
        .min_mode_i   (mm),
        .z_dig_o      (zd)
    );

    function automatic int dv(logic [1:0] d);
        if (d == 2'b10) return 1;
        if (d == 2'b01) return -1;
        return 0;
    endfunction

    function automatic int wval(logic [15:0] w);
        int v = 0;
        for (int i = 0; i < N; i++) v = v * 2 + dv(w[2*(N-1-i) +: 2]);
        return v;
    endfunction

    function automatic logic [15:0] enc_word(int hi, int last);
        logic [15:0] w = '0;
        int m = (hi < 0) ? -hi : hi;
        for (int i = 0; i < N-1; i++)
            if (((m >> (N-2-i)) & 1) == 1)
                w[2*(N-1-i) +: 2] = (hi < 0) ? 2'b01 : 2'b10;
        w[1:0] = (last == 1) ? 2'b10 : (last == -1) ? 2'b01 : 2'b00;
        return w;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_batch(int nw);
        for (int c = 0; c < nw*N + 3; c++) begin
            @(negedge clk);
            if (c >= 3) got_dig[(c-3)/N][(c-3)%N] = zd;
            else        pre_dig[c] = zd;
            if (c < nw*N) begin
                xd = wx[c/N][2*(N-1-c%N) +: 2];
                yd = wy[c/N][2*(N-1-c%N) +: 2];
                st = (c % N == 0);
                mm = (c % N == 0) ? wm[c/N] : ~wm[c/N];
            end else begin
                xd = 2'b00; yd = 2'b00; st = 1'b0; mm = 1'b0;
            end
        end
    endtask

    task automatic verify_batch(int nw, string base);
        for (int w = 0; w < nw; w++) begin
            int v = 0;
            int vx = wval(wx[w]);
            int vy = wval(wy[w]);
            int ex;
            bit canon = 1'b1;
            for (int i = 0; i < N; i++) begin
                v = v * 2 + dv(got_dig[w][i]);
                if (got_dig[w][i] == 2'b11) canon = 1'b0;
            end
            ex = wm[w] ? ((vx < vy) ? vx : vy) : ((vx > vy) ? vx : vy);
            check(v == ex, $sformatf("%s %s R6 word %0d", base,
                  wm[w] ? "R4" : "R3", w), v, ex);
            check(canon, $sformatf("R1 canonical digits word %0d", w),
                  canon, 1);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; xd = 2'b10; yd = 2'b01; st = 1'b1; mm = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(zd == 2'b00, "R8 output during reset", zd, 0);
        rst = 1'b0; xd = 2'b00; yd = 2'b00; st = 1'b0;

        // table rows: near ties, invalid zero code (R1), tie (R5)
        for (int k = 0; k < NTAB; k++) begin
            wm[k] = TAB[k][32];
            wx[k] = TAB[k][31:16];
            wy[k] = TAB[k][15:0];
        end
        run_batch(NTAB);
        check(pre_dig[2] == 2'b00, "R2 no digit before cycle 3",
              pre_dig[2], 0);
        check(got_dig[0][0] == 2'b10, "R2 first digit at cycle 3",
              got_dig[0][0], 2);
        verify_batch(NTAB, "R1 R5 table");

        // random operands, back to back
        for (int k = 0; k < 40; k++) begin
            wx[k] = 16'($urandom);
            wy[k] = 16'($urandom);
            wm[k] = 1'($urandom);
        end
        run_batch(40);
        verify_batch(40, "R7 random");

        // equal values, different encodings
        for (int k = 0; k < 10; k++) begin
            int v = 2 * int'($urandom % 120) - 119;
            wx[k] = enc_word((v - 1) / 2, 1);
            wy[k] = enc_word((v + 1) / 2, -1);
            wm[k] = 1'($urandom);
        end
        run_batch(10);
        verify_batch(10, "R5 tie");

        // decided at the first digit: output follows the winner
        for (int k = 0; k < 8; k++) begin
            wx[k] = {2'b10, 14'($urandom)};
            wy[k] = {2'b01, 14'($urandom)};
            wm[k] = k[0];
        end
        run_batch(8);
        for (int k = 0; k < 8; k++) begin
            int bad = 0;
            for (int i = 0; i < N; i++) begin
                logic [1:0] wd;
                wd = wm[k] ? wy[k][2*(N-1-i) +: 2] : wx[k][2*(N-1-i) +: 2];
                if (dv(got_dig[k][i]) != dv(wd)) bad++;
            end
            check(bad == 0, $sformatf("R9 winner digits word %0d", k), bad, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule